// File: doc/BRIEF.md
# Host Memory Address Range Decoder

The decoder sits on the path of upstream memory requests and chooses a destination for each one: host DRAM, the PCI Express port, the legacy downstream I/O port, the interrupt-message path, or an invalid-cycle response. Each request carries an address, a read/write flag and a requester port tag. The routing boundaries come from configuration inputs given in 1 MB units: the top of installed memory, the top of low usable DRAM, the top of upper usable DRAM, the size of a region reserved for the management engine, and a remap window. A single enable bit sends the interrupt-controller configuration window to PCI Express.

Fixed windows near the top of the 4 GB space are decoded before any programmed range. Addresses in the remap window are moved down so that DRAM hidden behind the MMIO hole below 4 GB can still be reached. The decode is combinational and is captured in one output register behind a valid/ready handshake. That register holds a one-hot target, the translated DRAM address, an error flag and the requester tag.

Top module: `mem_route_top`

## Requirements
- R1: A request whose address bit 39 is set (address at or above 2^39) gets the invalid target (one-hot bit 4) with the error flag set, whatever else matches.
- R2: Addresses 0xFFE0_0000 to 0xFFFF_FFFF always go to the legacy port (bit 2), even when a programmed DRAM range covers them.
- R3: A write in 0xFEE0_0000 to 0xFEEF_FFFF goes to the interrupt path (bit 3). A read there gets the invalid target with error set. Neither goes to DRAM.
- R4: Addresses 0xFEC0_0000 to 0xFECF_FFFF go to PCI Express (bit 1) when the APIC-forward enable is 1, and to the legacy port when it is 0. The address just above this window does not go to PCI Express.
- R5: Addresses from (clamped top of memory − stolen size) up to, but not including, the clamped top of memory get the invalid target with error set. The MB just below that base still decodes normally.
- R6: An address at or above 4 GB that lies within remap base..remap limit (limit inclusive, in MB) goes to DRAM (bit 0). Its DRAM address is addr − base·2^20 + lowTop·2^20.
- R7: An address below the top of low usable DRAM goes to DRAM unchanged. Addresses from that top up to 4 GB, including 0xFEDA_0000 to 0xFEDB_FFFF, fall through to the legacy port.
- R8: An address from 4 GB up to, but not including, the top of upper usable DRAM goes to DRAM unchanged. An address at or above that top goes to the legacy port. For every non-DRAM target the DRAM address output is 0.
- R9: A top-of-memory value above 32768 MB is treated as 32768 MB when the stolen region is placed.
- R10: reqReady equals (not rspValid) or rspReady. An accepted request shows up with rspValid exactly one cycle later and carries its requester tag. While rspValid is high and rspReady is low, every output field holds.
- R11: After reset rspValid is 0 and reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | 40 | Request address; bit 39 marks an out-of-range address |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqPort | input | 2 | Requester tag |
| cfgTopMem | input | 19 | Top of installed memory, MB |
| cfgLowTop | input | 19 | Top of low usable DRAM, MB |
| cfgHighTop | input | 19 | Top of upper usable DRAM, MB |
| cfgStolenSize | input | 19 | Management-engine stolen size, MB |
| cfgRemapBase | input | 19 | Remap window base, MB |
| cfgRemapLimit | input | 19 | Remap window last MB (inclusive) |
| cfgApicToPcie | input | 1 | Send the APIC window to PCI Express |
| rspValid | output | 1 | Decoded result present |
| rspReady | input | 1 | Result consumed |
| rspTarget | output | 5 | One-hot target: 0 DRAM, 1 PCIe, 2 legacy, 3 interrupt, 4 invalid |
| rspDramAddr | output | 39 | DRAM address for a DRAM target, else 0 |
| rspError | output | 1 | Invalid-cycle flag |
| rspPort | output | 2 | Requester tag of the result |

## Verification
Addresses are placed just inside and just outside every window edge: the 2^39 limit, the fixed BIOS, message and APIC windows, the stolen base, the remap limits, and both DRAM tops. An off-by-one compare or a wrong inclusive bound therefore shows up as a different target. The same addresses are sent as both reads and writes, and with the APIC enable both set and clear, which separates direction-dependent routing from address-only routing. Making low DRAM cover the whole 4 GB space shows whether the fixed windows really override it. An oversized top-of-memory value shows whether the clamp is applied. Stalls on rspReady are mixed with back-to-back traffic so that holding and the one-cycle latency are told apart.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  localparam int TGT_W = 5;
  localparam logic [TGT_W-1:0] TGT_DRAM    = 5'b00001;
  localparam logic [TGT_W-1:0] TGT_PCIE    = 5'b00010;
  localparam logic [TGT_W-1:0] TGT_LEGACY  = 5'b00100;
  localparam logic [TGT_W-1:0] TGT_INTR    = 5'b01000;
  localparam logic [TGT_W-1:0] TGT_INVALID = 5'b10000;

  // fixed windows below 4 GB, byte addresses, inclusive bounds
  localparam logic [31:0] BIOS_LO = 32'hFFE0_0000;
  localparam logic [31:0] BIOS_HI = 32'hFFFF_FFFF;
  localparam logic [31:0] MSG_LO  = 32'hFEE0_0000;
  localparam logic [31:0] MSG_HI  = 32'hFEEF_FFFF;
  localparam logic [31:0] APIC_LO = 32'hFEC0_0000;
  localparam logic [31:0] APIC_HI = 32'hFECF_FFFF;

  typedef struct packed {
    logic load;   // capture a new decode
    logic drop;   // current result consumed with nothing behind it
  } mrdStrobe_t;

endpackage

// File: rtl/mrd_ctrl.sv
module mrd_ctrl
  import mrd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rspReady,
  output logic       reqReady,
  output logic       rspValid,
  output mrdStrobe_t strobe
);

  logic validQ;

  assign reqReady    = !validQ || rspReady;
  assign strobe.load = reqValid && reqReady;
  assign strobe.drop = validQ && rspReady && !reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (strobe.drop) validQ <= 1'b0;
  end

  assign rspValid = validQ;

endmodule

// File: rtl/mrd_decode.sv
module mrd_decode
  import mrd_pkg::*;
#(
  parameter int ADDR_W      = 39,
  parameter int GRAN_W      = 20,
  parameter int DRAM_MAX_MB = 32768,
  localparam int CFG_W      = ADDR_W - GRAN_W
)(
  input  logic [ADDR_W:0]    addr,
  input  logic               isWrite,
  input  logic [CFG_W-1:0]   topMem,
  input  logic [CFG_W-1:0]   lowTop,
  input  logic [CFG_W-1:0]   highTop,
  input  logic [CFG_W-1:0]   stolenSize,
  input  logic [CFG_W-1:0]   remapBase,
  input  logic [CFG_W-1:0]   remapLimit,
  input  logic               apicToPcie,
  output logic [TGT_W-1:0]   target,
  output logic [ADDR_W-1:0]  dramAddr
);

  localparam logic [CFG_W-1:0] FOUR_G_MB = CFG_W'(1) << (32 - GRAN_W);
  localparam logic [CFG_W-1:0] MAX_MB    = CFG_W'(DRAM_MAX_MB);
  localparam int PAD_W = ADDR_W - 32;

  logic [ADDR_W-1:0] addrLow;
  logic [CFG_W-1:0]  addrMb;
  logic [CFG_W-1:0]  topClamped;
  logic [CFG_W-1:0]  stolenBase;
  logic [CFG_W-1:0]  remapMb;
  logic overRange, inBios, inMsg, inApic, inStolen, inRemap, inLowDram, inHighDram;

  function automatic logic inWindow(input logic [ADDR_W-1:0] a,
                                    input logic [31:0] lo, input logic [31:0] hi);
    return (a >= {{PAD_W{1'b0}}, lo}) && (a <= {{PAD_W{1'b0}}, hi});
  endfunction

  assign addrLow   = addr[ADDR_W-1:0];
  assign addrMb    = addr[ADDR_W-1:GRAN_W];
  assign overRange = addr[ADDR_W];

  assign topClamped = (topMem > MAX_MB) ? MAX_MB : topMem;
  assign stolenBase = (stolenSize > topClamped) ? '0 : topClamped - stolenSize;

  assign inBios     = inWindow(addrLow, BIOS_LO, BIOS_HI);
  assign inMsg      = inWindow(addrLow, MSG_LO, MSG_HI);
  assign inApic     = inWindow(addrLow, APIC_LO, APIC_HI);
  assign inStolen   = (addrMb >= stolenBase) && (addrMb < topClamped);
  assign inRemap    = (addrMb >= FOUR_G_MB) && (remapBase <= remapLimit) &&
                      (addrMb >= remapBase) && (addrMb <= remapLimit);
  assign inLowDram  = addrMb < lowTop;
  assign inHighDram = (addrMb >= FOUR_G_MB) && (addrMb < highTop);
  assign remapMb    = addrMb - remapBase + lowTop;

  always_comb begin
    target   = TGT_LEGACY;
    dramAddr = '0;
    if (overRange)       target = TGT_INVALID;
    else if (inBios)     target = TGT_LEGACY;
    else if (inMsg)      target = isWrite ? TGT_INTR : TGT_INVALID;
    else if (inApic)     target = apicToPcie ? TGT_PCIE : TGT_LEGACY;
    else if (inStolen)   target = TGT_INVALID;
    else if (inRemap) begin
      target   = TGT_DRAM;
      dramAddr = {remapMb, addrLow[GRAN_W-1:0]};
    end
    else if (inLowDram || inHighDram) begin
      target   = TGT_DRAM;
      dramAddr = addrLow;
    end
  end

endmodule

// File: rtl/mrd_datapath.sv
module mrd_datapath
  import mrd_pkg::*;
#(
  parameter int ADDR_W = 39,
  parameter int PORT_W = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  mrdStrobe_t        strobe,
  input  logic [TGT_W-1:0]  nextTarget,
  input  logic [ADDR_W-1:0] nextDramAddr,
  input  logic [PORT_W-1:0] nextPort,
  output logic [TGT_W-1:0]  target,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              error,
  output logic [PORT_W-1:0] port
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target   <= TGT_LEGACY;
      dramAddr <= '0;
      error    <= 1'b0;
      port     <= '0;
    end else if (strobe.load) begin
      target   <= nextTarget;
      dramAddr <= nextDramAddr;
      error    <= (nextTarget == TGT_INVALID);
      port     <= nextPort;
    end
  end

endmodule

// File: rtl/mem_route_top.sv
module mem_route_top
  import mrd_pkg::*;
#(
  parameter int ADDR_W      = 39,
  parameter int GRAN_W      = 20,
  parameter int PORT_W      = 2,
  parameter int DRAM_MAX_MB = 32768,
  localparam int CFG_W      = ADDR_W - GRAN_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [CFG_W-1:0]  cfgTopMem,
  input  logic [CFG_W-1:0]  cfgLowTop,
  input  logic [CFG_W-1:0]  cfgHighTop,
  input  logic [CFG_W-1:0]  cfgStolenSize,
  input  logic [CFG_W-1:0]  cfgRemapBase,
  input  logic [CFG_W-1:0]  cfgRemapLimit,
  input  logic              cfgApicToPcie,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [TGT_W-1:0]  rspTarget,
  output logic [ADDR_W-1:0] rspDramAddr,
  output logic              rspError,
  output logic [PORT_W-1:0] rspPort
);

  mrdStrobe_t        strobe;
  logic [TGT_W-1:0]  nextTarget;
  logic [ADDR_W-1:0] nextDramAddr;

  mrd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  mrd_decode #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .DRAM_MAX_MB(DRAM_MAX_MB)) u_decode (
    .addr(reqAddr), .isWrite(reqWrite),
    .topMem(cfgTopMem), .lowTop(cfgLowTop), .highTop(cfgHighTop),
    .stolenSize(cfgStolenSize), .remapBase(cfgRemapBase), .remapLimit(cfgRemapLimit),
    .apicToPcie(cfgApicToPcie), .target(nextTarget), .dramAddr(nextDramAddr)
  );

  mrd_datapath #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .nextTarget(nextTarget), .nextDramAddr(nextDramAddr), .nextPort(reqPort),
    .target(rspTarget), .dramAddr(rspDramAddr), .error(rspError), .port(rspPort)
  );

endmodule

// File: rtl/mem_route_chk.sv
module mem_route_chk
  import mrd_pkg::*;
#(
  parameter int ADDR_W      = 39,
  parameter int GRAN_W      = 20,
  parameter int PORT_W      = 2,
  parameter int DRAM_MAX_MB = 32768,
  localparam int CFG_W      = ADDR_W - GRAN_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W:0]   reqAddr,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              rspReady,
  input logic [TGT_W-1:0]  rspTarget,
  input logic [ADDR_W-1:0] rspDramAddr,
  input logic              rspError,
  input logic [PORT_W-1:0] rspPort
);

  logic accept;
  logic [31:0] lo32;
  logic below4g;
  assign accept  = reqValid && reqReady;
  assign lo32    = reqAddr[31:0];
  assign below4g = (reqAddr[ADDR_W:32] == '0);

  assert_invalid_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqAddr[ADDR_W]) |=> (rspTarget == TGT_INVALID && rspError));

  assert_bios_legacy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && below4g && lo32 >= BIOS_LO) |=> (rspTarget == TGT_LEGACY));

  assert_msg_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && below4g && reqWrite && lo32 >= MSG_LO && lo32 <= MSG_HI)
      |=> (rspTarget == TGT_INTR && !rspError));

  assert_zero_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspTarget[0]) |-> (rspDramAddr == '0));

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones(rspTarget) == 1));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspTarget) &&
      $stable(rspDramAddr) && $stable(rspError) && $stable(rspPort)));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady);

endmodule

bind mem_route_top mem_route_chk #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .PORT_W(PORT_W),
  .DRAM_MAX_MB(DRAM_MAX_MB)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqWrite(reqWrite), .rspValid(rspValid), .rspReady(rspReady),
  .rspTarget(rspTarget), .rspDramAddr(rspDramAddr), .rspError(rspError), .rspPort(rspPort)
);

// File: tb/mem_route_top_test.sv
module mem_route_top_test;
  localparam int CLK_PERIOD = 10;
  localparam longint MB = 64'd1 << 20;
  localparam longint G4 = 64'd1 << 32;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, rspReady = 1, cfgApicToPcie = 0;
  logic [39:0] reqAddr = '0;
  logic [1:0]  reqPort = '0;
  logic [18:0] cfgTopMem, cfgLowTop, cfgHighTop, cfgStolenSize, cfgRemapBase, cfgRemapLimit;
  logic reqReady, rspValid, rspError;
  logic [4:0]  rspTarget;
  logic [38:0] rspDramAddr;
  logic [1:0]  rspPort;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // model state
  bit      expValid = 0;
  int      expTgt = 4;
  longint  expAddr = 0;
  int      expPort = 0;

  int cTop, cLow, cHigh, cStolen, cRb, cRl;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_route_top uut (.*);

  task automatic setCfg(int top, int low, int high, int st, int rb, int rl);
    cTop = top; cLow = low; cHigh = high; cStolen = st; cRb = rb; cRl = rl;
    cfgTopMem = 19'(top); cfgLowTop = 19'(low); cfgHighTop = 19'(high);
    cfgStolenSize = 19'(st); cfgRemapBase = 19'(rb); cfgRemapLimit = 19'(rl);
  endtask

  // target returned as bit index: 0 DRAM 1 PCIe 2 legacy 3 interrupt 4 invalid
  function automatic void model(input longint a, input bit w, input bit apic,
                                output int t, output longint d);
    longint topB = ((cTop > 32768) ? 32768 : cTop) * MB;
    longint stB  = (cStolen * MB > topB) ? 0 : topB - cStolen * MB;
    d = 0;
    if (a >= (64'd1 << 39))                             t = 4;
    else if (a >= 64'hFFE0_0000 && a < G4)              t = 2;
    else if (a >= 64'hFEE0_0000 && a <= 64'hFEEF_FFFF)  t = w ? 3 : 4;
    else if (a >= 64'hFEC0_0000 && a <= 64'hFECF_FFFF)  t = apic ? 1 : 2;
    else if (a >= stB && a < topB)                      t = 4;
    else if (a >= G4 && cRb <= cRl && a >= cRb * MB && a < (cRl + 1) * MB) begin
      t = 0; d = a - cRb * MB + cLow * MB;
    end
    else if (a < cLow * MB || (a >= G4 && a < cHigh * MB)) begin
      t = 0; d = a;
    end
    else t = 2;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, compare at the next negedge
  task automatic cycle(bit v, longint a, bit w, int port, bit rdy, string tag);
    bit expReady;
    int t; longint d;
    reqValid = v; reqAddr = 40'(a); reqWrite = w; reqPort = 2'(port); rspReady = rdy;
    #1;
    expReady = !expValid || rdy;
    check(reqReady == expReady, "R10", "reqReady", longint'(reqReady), longint'(expReady));
    @(posedge clk);
    if (v && expReady) begin
      model(a, w, cfgApicToPcie, t, d);
      expValid = 1; expTgt = t; expAddr = d; expPort = port;
    end else if (rdy) expValid = 0;
    @(negedge clk);
    check(rspValid == expValid, tag, "rspValid", longint'(rspValid), longint'(expValid));
    if (expValid) begin
      check(rspTarget == 5'(1 << expTgt), tag, "target", longint'(rspTarget), 64'd1 << expTgt);
      check(rspDramAddr == 39'(expAddr), tag, "dramAddr", longint'(rspDramAddr), expAddr);
      check(rspError == (expTgt == 4), tag, "error", longint'(rspError), longint'(expTgt == 4));
      check(rspPort == 2'(expPort), tag, "port", longint'(rspPort), longint'(expPort));
    end
  endtask

  task automatic req(longint a, bit w, string tag);
    cycle(1, a, w, int'(a[5:4]), 1, tag);
  endtask

  initial begin
    setCfg(6144, 3072, 6144, 64, 8192, 9215);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rspValid == 0, "R11", "rspValid in reset", longint'(rspValid), 0);
    check(reqReady == 1, "R11", "reqReady in reset", longint'(reqReady), 1);
    rstN = 1;
    @(negedge clk);
    check(rspValid == 0, "R11", "rspValid after reset", longint'(rspValid), 0);

    // R1 address width limit
    req(64'h80_0000_0000, 0, "R1");
    req(64'h80_0000_0000, 1, "R1");
    req(64'h7F_FFFF_FFFF, 0, "R1");
    // R7 low DRAM, hole and the no-special-decode window
    req(64'h0000_1000, 0, "R7");
    req(64'hBFFF_FFFF, 1, "R7");
    req(64'hC000_0000, 0, "R7");
    req(64'hFEDA_0000, 1, "R7");
    req(64'hFEDB_FFFF, 0, "R7");
    // R3 message window
    req(64'hFEE0_0000, 1, "R3");
    req(64'hFEEF_FFFF, 1, "R3");
    req(64'hFEE0_0040, 0, "R3");
    // R4 APIC window
    cfgApicToPcie = 1;
    req(64'hFEC0_0000, 0, "R4");
    req(64'hFECF_FFFF, 1, "R4");
    req(64'hFED0_0000, 0, "R4");
    cfgApicToPcie = 0;
    req(64'hFEC0_0000, 0, "R4");
    req(64'hFECF_FFFF, 1, "R4");
    // R2 fixed BIOS window
    req(64'hFFE0_0000, 0, "R2");
    req(64'hFFFF_FFFF, 1, "R2");
    // R8 upper DRAM
    req(64'h1_0000_0000, 0, "R8");
    req(64'h1_7BFF_FFFF, 1, "R8");
    req(64'h1_8000_0000, 0, "R8");
    // R5 stolen region
    req(64'h1_7C00_0000, 0, "R5");
    req(64'h1_7FFF_FFFF, 1, "R5");
    // R6 remap window
    req(64'h2_0000_0000, 0, "R6");
    req(64'h2_1234_5678, 1, "R6");
    req(64'h2_3FFF_FFFF, 0, "R6");
    req(64'h2_4000_0000, 0, "R6");
    req(64'h1_FFFF_FFFF, 0, "R6");
    // R2 priority: low DRAM covering all of 4 GB
    setCfg(6144, 4096, 6144, 64, 8192, 9215);
    req(64'hFFDF_FFFF, 0, "R2");
    req(64'hFFE0_0000, 0, "R2");
    req(64'hFEE0_0000, 1, "R3");
    // R9 clamp of top of memory
    setCfg(40000, 3072, 40000, 64, 50000, 40000);
    req(64'h7FC_0000_0000 >> 4, 0, "R9");
    req(longint'(32704) * MB, 0, "R9");
    req(longint'(32704) * MB - 1, 1, "R9");
    req(longint'(32767) * MB, 0, "R9");
    req(longint'(32768) * MB, 0, "R9");
    setCfg(6144, 3072, 6144, 64, 8192, 9215);
    // R10 stall and hold, then back-to-back
    cycle(1, 64'h0000_2000, 0, 1, 0, "R10");
    cycle(1, 64'hFEE0_0000, 1, 2, 0, "R10");
    cycle(0, 0, 0, 0, 0, "R10");
    cycle(1, 64'hFEE0_0000, 1, 3, 1, "R10");
    cycle(1, 64'h1_0000_0000, 0, 2, 1, "R10");
    cycle(0, 0, 0, 0, 1, "R10");
    cycle(0, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 40; i++)
      cycle(i % 3 != 0, longint'(i) * 64'h0_7700_0000 + 64'h1000, i[0], i % 4, i % 5 != 0, "R10");
    cycle(0, 0, 0, 0, 1, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule